// File: doc/BRIEF.md
# Address Translation Cache with Context Flush

This block holds a handful of recent virtual-page-to-physical-frame mappings so that most address translations finish without a trip to the page table. Each lookup presents a page number and a byte offset. The page number is compared against every occupied entry in parallel within the same cycle. On a match the block returns the stored frame with the offset appended as the physical address. When no entry matches, it raises a walk request carrying the page number to an external table walker.

The walker answers through a fill port with the frame it found, or with a fault flag when the page has no valid mapping. Good answers are installed. An empty slot is used first. When every slot is occupied, the slot touched longest ago is overwritten. An answer for a page that is already cached rewrites that slot in place. A single flush input, pulsed on every context switch, empties the whole cache so that mappings from the previous process cannot match. Two free-running counters report lookups and hits for test.

Top module: `tlb_cache`

## Requirements
- R1: A lookup is resolved in the cycle it is presented. `hit` and `miss` are combinational, at most one of them is high, and both are low when `lookup_valid` is low.
- R2: On a hit, `phys_addr` equals the stored frame in the upper FRAME_W bits and `lookup_off` in the lower OFF_W bits, and `walk_req` stays low.
- R3: On a miss, `walk_req` is high in the same cycle and `walk_page` equals `lookup_page`.
- R4: A fill with `fill_fault` low is installed at the clock edge. A lookup of that page in any later cycle hits and returns the filled frame.
- R5: While any slot is empty, a fill of a new page takes an empty slot and evicts nothing.
- R6: When all DEPTH slots are occupied, a fill of a new page replaces the slot whose most recent hit or fill is the oldest. Hits and fills both count as touches.
- R7: A fill with `fill_fault` high changes nothing. A later lookup of that page misses, and earlier cached pages still hit.
- R8: A fill for a page already cached overwrites that slot's frame and evicts no other page.
- R9: A `flush` pulse empties every slot from the next cycle on, so every later lookup misses until new fills arrive.
- R10: A fill that arrives in the same cycle as `flush` is discarded.
- R11: `lookup_count` increments once per cycle with `lookup_valid` high, and `hit_count` increments once per hit. Flush does not clear either counter.
- R12: After reset every slot is empty and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A translation request is presented this cycle |
| lookup_page | input | PAGE_W | Virtual page number of the request |
| lookup_off | input | OFF_W | Byte offset within the page |
| hit | output | 1 | Request matched a cached mapping |
| miss | output | 1 | Request matched nothing |
| phys_addr | output | FRAME_W+OFF_W | Frame and offset on a hit, zero otherwise |
| walk_req | output | 1 | Ask the walker to resolve `walk_page` |
| walk_page | output | PAGE_W | Page the walker should resolve |
| fill_valid | input | 1 | Walker answer present |
| fill_page | input | PAGE_W | Page of the answer |
| fill_frame | input | FRAME_W | Frame of the answer |
| fill_fault | input | 1 | Page has no valid mapping; do not install |
| flush | input | 1 | Context switch: empty all slots |
| hit_count | output | CNT_W | Number of hits since reset |
| lookup_count | output | CNT_W | Number of lookups since reset |

## Verification
The assertions assume that a fill and a lookup never arrive in the same cycle. They also assume the walker never answers for a page while the same page is under lookup. Under these conditions a cycle's hit result depends only on the state left by earlier edges. The match checker further relies on the fact that one page can occupy at most one slot, which the in-place update on refill guarantees. The stimulus drives each operation in its own low clock phase and never overlaps a fill with a lookup. The only deliberate same-cycle combination is flush together with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // How a fill request is applied to the entry array
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int DEPTH  = 8,
  parameter int PAGE_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  valid_vec,
  input  logic [PAGE_W-1:0] tags [DEPTH],
  input  logic [PAGE_W-1:0] key,
  output logic [DEPTH-1:0]  match_oh,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_oh[g] = valid_vec[g] && (tags[g] == key);
    end
  endgenerate

  assign any = |match_oh;

  always_comb begin
    idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match_oh[i]) idx = idx | IDX_W'(i);
  end

  // R1: a page lives in at most one slot, so a key matches at most once
  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_oh));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [DEPTH-1:0] valid_vec,
  output logic [IDX_W-1:0] victim_idx
);
  // rank 0 = most recently touched, DEPTH-1 = least recently touched
  logic [IDX_W-1:0] rank_q [DEPTH];
  logic [DEPTH-1:0] oldest_oh;
  logic [IDX_W-1:0] oldest_idx;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == touch_idx)
          rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx])
          rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_old
      assign oldest_oh[g] = (rank_q[g] == IDX_W'(DEPTH - 1));
    end
  endgenerate

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (oldest_oh[i]) oldest_idx = IDX_W'(i);
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  // R5: an empty slot first; R6: otherwise the least recently touched one
  assign victim_idx = free_any ? free_idx : oldest_idx;

  // R6: ranks stay a permutation, so exactly one slot is the oldest
  a_r6_single_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_oh) == 1);
  // R6: a touched slot becomes the most recent one
  a_r6_touch_newest: assert property (@(posedge clk) disable iff (rst)
    touch |=> (rank_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int DEPTH   = 8,
  parameter int PAGE_W  = 8,
  parameter int FRAME_W = 8,
  parameter int OFF_W   = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lookup_valid,
  input  logic [PAGE_W-1:0]  lookup_page,
  input  logic [OFF_W-1:0]   lookup_off,
  output logic               hit,
  output logic               miss,
  output logic [PA_W-1:0]    phys_addr,
  output logic               walk_req,
  output logic [PAGE_W-1:0]  walk_page,
  input  logic               fill_valid,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_fault,
  input  logic               flush,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   lookup_count
);
  import tlb_pkg::*;

  logic [DEPTH-1:0]   valid_q;
  logic [PAGE_W-1:0]  page_q  [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];

  logic [DEPTH-1:0] lk_oh, fl_oh;
  logic             lk_any, fl_any;
  logic [IDX_W-1:0] lk_idx, fl_idx, victim_idx, tgt_idx, touch_idx;
  logic             fill_go, touch;
  fill_kind_e       fill_kind;

  // lookup path
  tlb_match #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) u_lk_match (
    .clk(clk), .rst(rst), .valid_vec(valid_q), .tags(page_q),
    .key(lookup_page), .match_oh(lk_oh), .any(lk_any), .idx(lk_idx));

  // fill path: detects a page that is already cached
  tlb_match #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) u_fl_match (
    .clk(clk), .rst(rst), .valid_vec(valid_q), .tags(page_q),
    .key(fill_page), .match_oh(fl_oh), .any(fl_any), .idx(fl_idx));

  tlb_lru #(.DEPTH(DEPTH)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid_vec(valid_q), .victim_idx(victim_idx));

  assign hit       = lookup_valid && lk_any;
  assign miss      = lookup_valid && !lk_any;
  assign phys_addr = hit ? {frame_q[lk_idx], lookup_off} : '0;
  assign walk_req  = miss;
  assign walk_page = lookup_page;

  // flush beats fill (R10); faulting answers are dropped (R7)
  assign fill_go = fill_valid && !fill_fault && !flush;

  always_comb begin
    if (!fill_go)                fill_kind = FILL_NONE;
    else if (fl_any)             fill_kind = FILL_UPDATE;
    else if (!valid_q[victim_idx]) fill_kind = FILL_FREE;
    else                         fill_kind = FILL_EVICT;
  end

  assign tgt_idx   = (fill_kind == FILL_UPDATE) ? fl_idx : victim_idx;
  assign touch     = fill_go || hit;
  assign touch_idx = fill_go ? tgt_idx : lk_idx;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (fill_kind != FILL_NONE) begin
      valid_q[tgt_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_kind != FILL_NONE) begin
      page_q[tgt_idx]  <= fill_page;
      frame_q[tgt_idx] <= fill_frame;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_count    <= '0;
      lookup_count <= '0;
    end else begin
      if (lookup_valid) lookup_count <= lookup_count + 1'b1;
      if (hit)          hit_count    <= hit_count + 1'b1;
    end
  end

  // R9: a flush leaves no slot able to match
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hit);
  // R10: a fill arriving together with a flush installs nothing
  a_r10_flush_wins: assert property (@(posedge clk) disable iff (rst)
    (flush && fill_valid) |=> (valid_q == '0));
  // R7: a faulting answer leaves occupancy untouched
  a_r7_fault_ignored: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_fault && !flush) |=> $stable(valid_q));
  // R4: a good fill is visible to the very next lookup of that page
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> (!(lookup_valid && lookup_page == $past(fill_page)) || hit));
  // R11: counters advance exactly with their events
  a_r11_hit_count: assert property (@(posedge clk) disable iff (rst)
    hit |=> (hit_count == CNT_W'($past(hit_count) + 1'b1)));
  a_r11_lookup_idle: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> $stable(lookup_count));
endmodule

// File: tb/sim_tlb_cache.sv
`timescale 1ns/1ps
module sim_tlb_cache;
  localparam int PAGE_W = 8, FRAME_W = 8, OFF_W = 8, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lookup_valid = 1'b0, fill_valid = 1'b0, fill_fault = 1'b0, flush = 1'b0;
  logic [PAGE_W-1:0]  lookup_page = '0, fill_page = '0;
  logic [OFF_W-1:0]   lookup_off = '0;
  logic [FRAME_W-1:0] fill_frame = '0;
  logic hit, miss, walk_req;
  logic [FRAME_W+OFF_W-1:0] phys_addr;
  logic [PAGE_W-1:0] walk_page;
  logic [CNT_W-1:0] hit_count, lookup_count;

  always #10 clk = ~clk;

  tlb_cache u0 (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_page(lookup_page),
    .lookup_off(lookup_off), .hit(hit), .miss(miss), .phys_addr(phys_addr),
    .walk_req(walk_req), .walk_page(walk_page), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_frame(fill_frame), .fill_fault(fill_fault),
    .flush(flush), .hit_count(hit_count), .lookup_count(lookup_count));

  int n_run = 0, n_fail = 0, exp_lk = 0, exp_hit = 0;
  bit done = 1'b0;

  // scoreboard entries: expected hit flag, physical address, page, requirement
  logic           q_hit  [$];
  logic [15:0]    q_pa   [$];
  logic [7:0]     q_page [$];
  string          q_req  [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lookup_valid = 0; fill_valid = 0; fill_fault = 0; flush = 0;
  endtask

  task automatic do_lookup(input logic [7:0] pg, input logic [7:0] off,
                           input bit eh, input logic [7:0] frame, input string req);
    @(negedge clk);
    fill_valid = 0; fill_fault = 0; flush = 0;
    lookup_valid = 1; lookup_page = pg; lookup_off = off;
    q_hit.push_back(eh);
    q_pa.push_back(eh ? {frame, off} : 16'h0);
    q_page.push_back(pg);
    q_req.push_back(req);
    exp_lk++;
    if (eh) exp_hit++;
  endtask

  task automatic do_fill(input logic [7:0] pg, input logic [7:0] frame,
                         input bit fault, input bit fl);
    @(negedge clk);
    lookup_valid = 0;
    fill_valid = 1; fill_page = pg; fill_frame = frame; fill_fault = fault; flush = fl;
  endtask

  task automatic do_flush();
    @(negedge clk);
    lookup_valid = 0; fill_valid = 0; fill_fault = 0; flush = 1;
  endtask

  // monitor: compares every lookup in the low phase of its cycle
  always begin
    @(negedge clk);
    #5;
    if (lookup_valid && q_hit.size() > 0) begin
      logic eh; logic [15:0] ep; logic [7:0] pg; string rq;
      eh = q_hit.pop_front(); ep = q_pa.pop_front();
      pg = q_page.pop_front(); rq = q_req.pop_front();
      check(hit == eh && miss == !eh, {rq, " R1 hit/miss"}, {hit, miss}, {eh, !eh});
      if (eh) check(phys_addr == ep && !walk_req, {rq, " R2 phys"}, phys_addr, ep);
      else    check(walk_req && walk_page == pg, {rq, " R3 walk"}, {walk_req, walk_page}, {1'b1, pg});
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #5;
    // R12 reset state and R1 idle outputs
    check(hit_count == 0 && lookup_count == 0, "R12 counters", {hit_count, lookup_count}, 0);
    check(!hit && !miss && !walk_req, "R1 idle", {hit, miss, walk_req}, 0);

    do_lookup(8'h05, 8'h14, 0, 8'h00, "R12 empty");
    do_fill(8'h05, 8'h30, 0, 0);
    do_lookup(8'h05, 8'h14, 1, 8'h30, "R4 installed");
    // R7: faulting answer is dropped
    do_fill(8'h09, 8'h77, 1, 0);
    do_lookup(8'h09, 8'h01, 0, 8'h00, "R7 fault miss");
    do_lookup(8'h05, 8'h02, 1, 8'h30, "R7 others kept");
    // R5: fill the remaining seven empty slots
    for (int i = 0; i < 7; i++) do_fill(8'h10 + 8'(i), 8'h40 + 8'(i), 0, 0);
    for (int i = 0; i < 7; i++)
      do_lookup(8'h10 + 8'(i), 8'(i), 1, 8'h40 + 8'(i), "R5 no eviction");
    // recency now oldest..newest: 05,10..16; touch 10 and 05 -> oldest is 11
    do_lookup(8'h10, 8'h00, 1, 8'h40, "R6 touch");
    do_lookup(8'h05, 8'h00, 1, 8'h30, "R6 touch");
    do_fill(8'h20, 8'hAA, 0, 0);
    do_lookup(8'h11, 8'h03, 0, 8'h00, "R6 lru evicted");
    do_lookup(8'h20, 8'h55, 1, 8'hAA, "R6 new entry");
    do_lookup(8'h12, 8'h04, 1, 8'h42, "R6 survivor");
    do_lookup(8'h05, 8'h04, 1, 8'h30, "R6 survivor");
    // R8: refill of a cached page while full
    do_fill(8'h20, 8'hBB, 0, 0);
    do_lookup(8'h20, 8'h66, 1, 8'hBB, "R8 updated");
    for (int i = 0; i < 7; i++)
      if (i != 1) do_lookup(8'h10 + 8'(i), 8'h07, 1, 8'h40 + 8'(i), "R8 no eviction");
    do_lookup(8'h05, 8'h08, 1, 8'h30, "R8 no eviction");
    // R11 counters before flush
    idle(); #5;
    check(lookup_count == CNT_W'(exp_lk), "R11 lookups", lookup_count, exp_lk);
    check(hit_count == CNT_W'(exp_hit), "R11 hits", hit_count, exp_hit);
    // R9 + R10: flush together with a fill
    do_fill(8'h30, 8'hCC, 0, 1);
    do_lookup(8'h30, 8'h01, 0, 8'h00, "R10 fill discarded");
    do_lookup(8'h05, 8'h01, 0, 8'h00, "R9 flushed");
    do_lookup(8'h20, 8'h01, 0, 8'h00, "R9 flushed");
    do_lookup(8'h14, 8'h01, 0, 8'h00, "R9 flushed");
    do_fill(8'h40, 8'h0E, 0, 0);
    do_lookup(8'h40, 8'hFF, 1, 8'h0E, "R4 after flush");
    do_flush();
    do_lookup(8'h40, 8'hFF, 0, 8'h00, "R9 plain flush");
    idle(); #5;
    check(lookup_count == CNT_W'(exp_lk), "R11 lookups kept", lookup_count, exp_lk);
    check(hit_count == CNT_W'(exp_hit), "R11 hits kept", hit_count, exp_hit);
    check(q_hit.size() == 0, "R1 scoreboard drained", q_hit.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule